// File: doc/BRIEF.md
# Associative Page Translator

This block maps 18-bit virtual word addresses onto 22-bit physical word addresses in 512-word pages. The upper nine address bits select a virtual page and the lower nine pass through unchanged as the word offset. A 32-slot fully associative store keeps recent page mappings. Every slot is compared in parallel on each lookup. Each slot is tagged with the address space it belongs to, either user or executive, because the two spaces are mapped independently.

A lookup supplies the address, a space select, the current processor mode and a read/write flag. One clock later the block gives a single-cycle result pulse. That pulse carries either the physical address or a fault with a two-bit cause. A miss is reported as a fault and is not resolved inside the block. An outside agent fetches the mapping and writes it in through the refill port. Two flush inputs invalidate either every slot or only the user-space slots. The second one is used on a user context switch.

Processor modes are encoded 2'b00 kernel, 2'b01 supervisor, 2'b10 concealed and 2'b11 public.

Top module: `assoc_page_xlate`

## Requirements
- R1: After reset every slot is invalid, `rsValid` is low, and any lookup faults with cause 2'b00 (miss).
- R2: A lookup accepted on a clock edge produces `rsValid` high for exactly the following cycle. `rsValid` is low in any cycle that does not follow an accepted lookup.
- R3: A lookup that hits a slot with its space and page, and that raises no fault, returns `rsFault`=0 and `rsPaddr` = {13-bit physical page, 9-bit offset}. A faulting result returns `rsPaddr`=0.
- R4: A slot matches only lookups whose space select (`lkUser`, 1 = user, 0 = executive) equals the slot's tag. Otherwise the lookup misses with cause 2'b00.
- R5: A hit on a slot whose accessible bit is 0 faults with cause 2'b01. This cause outranks every other cause.
- R6: A hit in public mode (2'b11) on a slot whose public bit is 0 faults with cause 2'b11. This cause outranks write protection. Other modes ignore the public bit.
- R7: A write that hits a slot whose writable bit is 0 faults with cause 2'b10. A read of the same slot succeeds.
- R8: A refill whose space and page match a valid slot overwrites that slot. Otherwise it goes into the lowest-numbered invalid slot. If every slot is valid, it replaces the slot named by a round-robin pointer. That pointer starts at 0 after reset and advances by one only on such a replacement.
- R9: `flushAll` invalidates every slot for lookups from the next cycle on. A refill in the same cycle as either flush input is dropped.
- R10: `flushUser` invalidates only user-space slots. Executive-space slots keep translating.
- R11: A lookup and a refill of the same space and page in the same cycle: the lookup sees the state before the refill and misses. The next lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 18 | Virtual word address |
| lkUser | input | 1 | Space select: 1 user, 0 executive |
| lkMode | input | 2 | Processor mode |
| lkWrite | input | 1 | 1 for a write access |
| rfValid | input | 1 | Refill request |
| rfUser | input | 1 | Space of the mapping being loaded |
| rfVpage | input | 9 | Virtual page of the mapping |
| rfPpage | input | 13 | Physical page of the mapping |
| rfAccess | input | 1 | Accessible bit |
| rfWritable | input | 1 | Writable bit |
| rfPublic | input | 1 | Public bit |
| flushAll | input | 1 | Invalidate all slots |
| flushUser | input | 1 | Invalidate user-space slots |
| rsValid | output | 1 | Result pulse |
| rsFault | output | 1 | Result is a fault |
| rsCause | output | 2 | Fault cause |
| rsPaddr | output | 22 | Physical word address |

## Verification
The translation is tried against a small set of loaded slots. The lookups vary space select, mode and direction so that each cause code arises once in isolation and once where a higher-ranked cause competes with it. Each of these cases separates one ordering of the permission checks from another.

Lookups on the same page under the other space tell tag matching apart from page matching alone. Back-to-back and idle cycles separate a pulsed result from a held one.

A fill of all 32 slots followed by further refills shows whether the victim follows the pointer or a fixed slot. An overwrite refill shows whether a matching slot is reused without moving that pointer. Same-cycle refill/lookup and flush/refill pairs check the ordering rules.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W        = 18;
  localparam int OFF_W       = 9;
  localparam int VPN_W       = VA_W - OFF_W;
  localparam int PPN_W       = 13;
  localparam int PA_W        = PPN_W + OFF_W;
  localparam int NUM_ENTRIES = 32;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);

  typedef enum logic [1:0] {
    MODE_KERNEL  = 2'b00,
    MODE_SUPER   = 2'b01,
    MODE_CONCEAL = 2'b10,
    MODE_PUBLIC  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    CAUSE_MISS  = 2'b00,
    CAUSE_NOACC = 2'b01,
    CAUSE_WPROT = 2'b10,
    CAUSE_MODE  = 2'b11
  } cause_e;

  typedef struct packed {
    logic             valid;
    logic             user;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             acc;
    logic             wr;
    logic             pub;
  } entry_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             clrAll;
    logic             clrUser;
    logic             ldResult;
    logic             fault;
    cause_e           cause;
  } strobe_t;
endpackage

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic             lkUser,
  input  logic             rfUser,
  input  logic [VPN_W-1:0] rfVpage,
  input  logic [PPN_W-1:0] rfPpage,
  input  logic             rfAccess,
  input  logic             rfWritable,
  input  logic             rfPublic,
  output logic             lkHit,
  output logic             hitAcc,
  output logic             hitWr,
  output logic             hitPub,
  output logic             rfMatchAny,
  output logic [IDX_W-1:0] rfMatchIdx,
  output logic             freeAny,
  output logic [IDX_W-1:0] freeIdx,
  output logic             rsValid,
  output logic             rsFault,
  output logic [1:0]       rsCause,
  output logic [PA_W-1:0]  rsPaddr
);
  entry_t                 slots [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] lkMatch;
  logic [NUM_ENTRIES-1:0] rfMatch;
  logic [NUM_ENTRIES-1:0] slotFree;
  logic [PPN_W-1:0]       hitPpn;
  logic [VPN_W-1:0]       lkVpn;
  logic [OFF_W-1:0]       lkOff;

  assign lkVpn = lkVaddr[VA_W-1:OFF_W];
  assign lkOff = lkVaddr[OFF_W-1:0];

  // Parallel compare of every slot against both ports
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign lkMatch[g]  = slots[g].valid && (slots[g].user == lkUser) && (slots[g].vpn == lkVpn);
    assign rfMatch[g]  = slots[g].valid && (slots[g].user == rfUser) && (slots[g].vpn == rfVpage);
    assign slotFree[g] = !slots[g].valid;
  end

  // At most one slot matches, so an OR of masked fields selects it
  always_comb begin
    hitPpn = '0;
    hitAcc = 1'b0;
    hitWr  = 1'b0;
    hitPub = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lkMatch[i]) begin
        hitPpn = hitPpn | slots[i].ppn;
        hitAcc = hitAcc | slots[i].acc;
        hitWr  = hitWr  | slots[i].wr;
        hitPub = hitPub | slots[i].pub;
      end
    end
  end
  assign lkHit = |lkMatch;

  // Lowest-index encoders for refill placement
  always_comb begin
    rfMatchIdx = '0;
    freeIdx    = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (rfMatch[i])  rfMatchIdx = IDX_W'(i);
      if (slotFree[i]) freeIdx    = IDX_W'(i);
    end
  end
  assign rfMatchAny = |rfMatch;
  assign freeAny    = |slotFree;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (stb.clrAll || (stb.clrUser && slots[i].user)) begin
          slots[i].valid <= 1'b0;
        end else if (stb.wrEn && stb.wrIdx == IDX_W'(i)) begin
          slots[i] <= '{valid: 1'b1, user: rfUser, vpn: rfVpage, ppn: rfPpage,
                        acc: rfAccess, wr: rfWritable, pub: rfPublic};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsValid <= 1'b0;
      rsFault <= 1'b0;
      rsCause <= 2'b00;
      rsPaddr <= '0;
    end else begin
      rsValid <= stb.ldResult;
      rsFault <= stb.ldResult && stb.fault;
      rsCause <= stb.ldResult ? stb.cause : 2'b00;
      rsPaddr <= (stb.ldResult && !stb.fault) ? {hitPpn, lkOff} : '0;
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [1:0]       lkMode,
  input  logic             lkWrite,
  input  logic             lkHit,
  input  logic             hitAcc,
  input  logic             hitWr,
  input  logic             hitPub,
  input  logic             rfValid,
  input  logic             rfMatchAny,
  input  logic [IDX_W-1:0] rfMatchIdx,
  input  logic             freeAny,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic             flushAll,
  input  logic             flushUser,
  output strobe_t          stb
);
  logic [IDX_W-1:0] rrPtr;
  logic             replace;

  // Permission ladder: accessible, then mode, then write protection
  always_comb begin
    stb.fault = 1'b1;
    stb.cause = CAUSE_MISS;
    if (lkHit) begin
      if (!hitAcc) begin
        stb.cause = CAUSE_NOACC;
      end else if (mode_e'(lkMode) == MODE_PUBLIC && !hitPub) begin
        stb.cause = CAUSE_MODE;
      end else if (lkWrite && !hitWr) begin
        stb.cause = CAUSE_WPROT;
      end else begin
        stb.fault = 1'b0;
      end
    end
  end

  assign stb.ldResult = lkValid;
  assign stb.clrAll   = flushAll;
  assign stb.clrUser  = flushUser;
  assign stb.wrEn     = rfValid && !flushAll && !flushUser;
  assign replace      = stb.wrEn && !rfMatchAny && !freeAny;
  assign stb.wrIdx    = rfMatchAny ? rfMatchIdx : (freeAny ? freeIdx : rrPtr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (replace) begin
      rrPtr <= (rrPtr == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/assoc_page_xlate.sv
module assoc_page_xlate
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic             lkUser,
  input  logic [1:0]       lkMode,
  input  logic             lkWrite,
  input  logic             rfValid,
  input  logic             rfUser,
  input  logic [VPN_W-1:0] rfVpage,
  input  logic [PPN_W-1:0] rfPpage,
  input  logic             rfAccess,
  input  logic             rfWritable,
  input  logic             rfPublic,
  input  logic             flushAll,
  input  logic             flushUser,
  output logic             rsValid,
  output logic             rsFault,
  output logic [1:0]       rsCause,
  output logic [PA_W-1:0]  rsPaddr
);
  strobe_t          stb;
  logic             lkHit, hitAcc, hitWr, hitPub;
  logic             rfMatchAny, freeAny;
  logic [IDX_W-1:0] rfMatchIdx, freeIdx;

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkMode(lkMode), .lkWrite(lkWrite),
    .lkHit(lkHit), .hitAcc(hitAcc), .hitWr(hitWr), .hitPub(hitPub),
    .rfValid(rfValid), .rfMatchAny(rfMatchAny), .rfMatchIdx(rfMatchIdx),
    .freeAny(freeAny), .freeIdx(freeIdx), .flushAll(flushAll), .flushUser(flushUser),
    .stb(stb)
  );

  xlate_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lkVaddr(lkVaddr), .lkUser(lkUser),
    .rfUser(rfUser), .rfVpage(rfVpage), .rfPpage(rfPpage), .rfAccess(rfAccess),
    .rfWritable(rfWritable), .rfPublic(rfPublic),
    .lkHit(lkHit), .hitAcc(hitAcc), .hitWr(hitWr), .hitPub(hitPub),
    .rfMatchAny(rfMatchAny), .rfMatchIdx(rfMatchIdx), .freeAny(freeAny), .freeIdx(freeIdx),
    .rsValid(rsValid), .rsFault(rsFault), .rsCause(rsCause), .rsPaddr(rsPaddr)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk
  import xlate_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [VA_W-1:0] lkVaddr,
  input logic [1:0]      lkMode,
  input logic            lkWrite,
  input logic            flushAll,
  input logic            rsValid,
  input logic            rsFault,
  input logic [1:0]      rsCause,
  input logic [PA_W-1:0] rsPaddr
);
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rsValid);

  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rsValid);

  assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && !rsFault) |-> rsPaddr[OFF_W-1:0] == $past(lkVaddr[OFF_W-1:0]));

  assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    rsFault |-> (rsPaddr == '0 && rsValid));

  assert_mode_cause_public_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rsFault && rsCause == 2'b11) |-> $past(lkMode) == 2'b11);

  assert_wprot_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rsFault && rsCause == 2'b10) |-> $past(lkWrite));

  assert_flush_then_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && $past(flushAll)) |=> (rsFault && rsCause == 2'b00));
endmodule

bind assoc_page_xlate xlate_chk u_chk (.*);

// File: tb/test_assoc_page_xlate.sv
module test_assoc_page_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic        user;
    logic [17:0] va;
    logic [1:0]  mode;
    logic        wr;
    logic        expFault;
    logic [1:0]  expCause;
    logic [21:0] expPa;
  } vec_t;

  // Slots loaded before the walk:
  //  A user 003 -> 0abc acc wr pub ; B exec 003 -> 1001 acc only
  //  C user 010 -> 0055 not accessible ; D user 020 -> 0777 acc, no wr, no pub
  localparam vec_t VECS [NV] = '{
    '{1'b1, {9'h003, 9'h1ff}, 2'd3, 1'b0, 1'b0, 2'd0, {13'h0abc, 9'h1ff}}, // R3 public read
    '{1'b1, {9'h003, 9'h000}, 2'd0, 1'b1, 1'b0, 2'd0, {13'h0abc, 9'h000}}, // R3 write
    '{1'b0, {9'h003, 9'h022}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h1001, 9'h022}}, // R4 exec tag
    '{1'b0, {9'h003, 9'h022}, 2'd0, 1'b1, 1'b1, 2'd2, 22'h0},              // R7
    '{1'b0, {9'h003, 9'h005}, 2'd3, 1'b0, 1'b1, 2'd3, 22'h0},              // R6
    '{1'b1, {9'h010, 9'h001}, 2'd0, 1'b0, 1'b1, 2'd1, 22'h0},              // R5
    '{1'b1, {9'h010, 9'h001}, 2'd3, 1'b1, 1'b1, 2'd1, 22'h0},              // R5 priority
    '{1'b1, {9'h020, 9'h0aa}, 2'd3, 1'b1, 1'b1, 2'd3, 22'h0},              // R6 over write
    '{1'b1, {9'h020, 9'h0aa}, 2'd2, 1'b1, 1'b1, 2'd2, 22'h0},              // R7 concealed
    '{1'b1, {9'h004, 9'h000}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0},              // R4 miss
    '{1'b0, {9'h010, 9'h001}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0}               // R4 other space
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, lkUser = 1'b0, lkWrite = 1'b0;
  logic [17:0] lkVaddr = '0;
  logic [1:0]  lkMode = '0;
  logic        rfValid = 1'b0, rfUser = 1'b0, rfAccess = 1'b0, rfWritable = 1'b0, rfPublic = 1'b0;
  logic [8:0]  rfVpage = '0;
  logic [12:0] rfPpage = '0;
  logic        flushAll = 1'b0, flushUser = 1'b0;
  logic        rsValid, rsFault;
  logic [1:0]  rsCause;
  logic [21:0] rsPaddr;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assoc_page_xlate i_assoc_page_xlate (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr), .lkUser(lkUser),
    .lkMode(lkMode), .lkWrite(lkWrite), .rfValid(rfValid), .rfUser(rfUser),
    .rfVpage(rfVpage), .rfPpage(rfPpage), .rfAccess(rfAccess), .rfWritable(rfWritable),
    .rfPublic(rfPublic), .flushAll(flushAll), .flushUser(flushUser),
    .rsValid(rsValid), .rsFault(rsFault), .rsCause(rsCause), .rsPaddr(rsPaddr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic setLook(input logic u, input logic [17:0] va, input logic [1:0] m, input logic w);
    lkValid = 1'b1; lkUser = u; lkVaddr = va; lkMode = m; lkWrite = w;
  endtask

  task automatic setRefill(input logic u, input logic [8:0] vp, input logic [12:0] pp,
                           input logic a, input logic w, input logic p);
    rfValid = 1'b1; rfUser = u; rfVpage = vp; rfPpage = pp;
    rfAccess = a; rfWritable = w; rfPublic = p;
  endtask

  task automatic refill(input logic u, input logic [8:0] vp, input logic [12:0] pp,
                        input logic a, input logic w, input logic p);
    setRefill(u, vp, pp, a, w, p);
    @(negedge clk);
    rfValid = 1'b0;
  endtask

  task automatic expectResult(input string req, input logic f, input logic [1:0] c, input logic [21:0] pa);
    chk(req, "rsValid", 32'(rsValid), 32'd1);
    chk(req, "rsFault", 32'(rsFault), 32'(f));
    chk(req, "rsCause", 32'(rsCause), 32'(c));
    chk(req, "rsPaddr", 32'(rsPaddr), 32'(pa));
  endtask

  task automatic look(input string req, input logic u, input logic [17:0] va, input logic [1:0] m,
                      input logic w, input logic f, input logic [1:0] c, input logic [21:0] pa);
    setLook(u, va, m, w);
    @(negedge clk);
    lkValid = 1'b0;
    expectResult(req, f, c, pa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rsValid idle", 32'(rsValid), 32'd0);
    look("R1", 1'b1, {9'h003, 9'h000}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0);
    look("R1", 1'b0, {9'h000, 9'h000}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0);

    refill(1'b1, 9'h003, 13'h0abc, 1'b1, 1'b1, 1'b1);
    refill(1'b0, 9'h003, 13'h1001, 1'b1, 1'b0, 1'b0);
    refill(1'b1, 9'h010, 13'h0055, 1'b0, 1'b1, 1'b1);
    refill(1'b1, 9'h020, 13'h0777, 1'b1, 1'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      look("R3-table", VECS[k].user, VECS[k].va, VECS[k].mode, VECS[k].wr,
           VECS[k].expFault, VECS[k].expCause, VECS[k].expPa);
    end

    // R2: back-to-back lookups give two pulses, then idle
    setLook(1'b1, {9'h003, 9'h011}, 2'd0, 1'b0);
    @(negedge clk);
    setLook(1'b0, {9'h003, 9'h012}, 2'd0, 1'b0);
    expectResult("R2", 1'b0, 2'd0, {13'h0abc, 9'h011});
    @(negedge clk);
    lkValid = 1'b0;
    expectResult("R2", 1'b0, 2'd0, {13'h1001, 9'h012});
    @(negedge clk);
    chk("R2", "rsValid after idle", 32'(rsValid), 32'd0);

    // R11: same-cycle refill and lookup of one page
    setRefill(1'b1, 9'h030, 13'h0123, 1'b1, 1'b1, 1'b1);
    setLook(1'b1, {9'h030, 9'h044}, 2'd0, 1'b0);
    @(negedge clk);
    rfValid = 1'b0; lkValid = 1'b0;
    expectResult("R11", 1'b1, 2'd0, 22'h0);
    look("R11", 1'b1, {9'h030, 9'h044}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h0123, 9'h044});

    // R10: user flush keeps executive slots
    flushUser = 1'b1;
    @(negedge clk);
    flushUser = 1'b0;
    look("R10", 1'b1, {9'h003, 9'h001}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0);
    look("R10", 1'b0, {9'h003, 9'h001}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h1001, 9'h001});

    // R9: full flush drops a same-cycle refill
    flushAll = 1'b1;
    setRefill(1'b0, 9'h040, 13'h0444, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    flushAll = 1'b0; rfValid = 1'b0;
    look("R9", 1'b0, {9'h003, 9'h001}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0);
    look("R9", 1'b0, {9'h040, 9'h001}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0);

    // R8: fill all slots, then round-robin replacement and overwrite
    for (int i = 0; i < 32; i++) refill(1'b1, 9'(i), 13'(i + 32'h100), 1'b1, 1'b1, 1'b1);
    look("R8", 1'b1, {9'h01f, 9'h007}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h011f, 9'h007});
    refill(1'b1, 9'h100, 13'h1f00, 1'b1, 1'b1, 1'b1);
    look("R8", 1'b1, {9'h000, 9'h007}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0);
    look("R8", 1'b1, {9'h001, 9'h007}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h0101, 9'h007});
    look("R8", 1'b1, {9'h100, 9'h007}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h1f00, 9'h007});
    refill(1'b1, 9'h101, 13'h1f01, 1'b1, 1'b1, 1'b1);
    look("R8", 1'b1, {9'h001, 9'h007}, 2'd0, 1'b0, 1'b1, 2'd0, 22'h0);
    look("R8", 1'b1, {9'h002, 9'h007}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h0102, 9'h007});
    refill(1'b1, 9'h005, 13'h0bad, 1'b1, 1'b1, 1'b1);
    look("R8", 1'b1, {9'h005, 9'h007}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h0bad, 9'h007});
    look("R8", 1'b1, {9'h002, 9'h007}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h0102, 9'h007});
    look("R8", 1'b1, {9'h101, 9'h007}, 2'd0, 1'b0, 1'b0, 2'd0, {13'h1f01, 9'h007});

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule